// File: doc/BRIEF.md
# LIN bus break and edge monitor

This block watches the receive line of a LIN bus and turns what it sees into single-cycle event pulses. The line is passed through a two-flop synchronizer. All edge and level decisions use the synchronized copy. While the line is low, a prescaler divides the system clock down to nominal bit times and a counter accumulates whole bit times. A low period that reaches 11 bit times is reported as a break when the line returns high.

The first break after the monitor is enabled gets an extra length check against a programmable maximum. Within each frame, falling edges are counted. Reaching 57 of them raises an overflow event. Each recognized break starts a new frame. A strobe from the byte receiver marks the stop-bit sample point, and a low line at that point is reported as a frame error. Dropping the enable returns every counter and flag to idle.

The block is meant to sit beside a LIN byte receiver. Its pulses feed a status register that lives outside the block.

Top module: `lin_brk_mon`

## Requirements
- R1: When the synchronized line has been low for at least 11 × `bit_div_i` clocks and then goes high, `brk_o` is high for exactly one cycle. It appears in the cycle after the third rising clock edge that follows `rx_i` going high.
- R2: A low period shorter than 11 × `bit_div_i` clocks produces no `brk_o` pulse.
- R3: A line held low for much longer than a break gives exactly one `brk_o` pulse, at the return to high, and none while the line stays low.
- R4: On the first break after enable, `brk_long_o` pulses together with `brk_o` when the low time in whole bit times (saturating at 255) is at least `brk_max_i`. An equal value counts as long. Otherwise `brk_long_o` stays low.
- R5: Breaks after the first one following an enable never raise `brk_long_o`. A new rising edge of `en_i` arms the check again.
- R6: `edge_ovf_o` pulses once, in the cycle after the 57th synchronized falling edge within a frame. The edge count saturates there, so further edges give no more pulses.
- R7: A recognized break clears the falling-edge count. A further 57 falling edges are then needed for the next overflow pulse.
- R8: When `stop_smp_i` is high and the synchronized line is low, `frm_err_o` pulses in the next cycle. A strobe taken while the line is high gives no pulse.
- R9: While `en_i` is low, no output pulses. All counts are cleared, so low time and falling edges seen before a disable do not carry across it.
- R10: During and straight after reset, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Monitor enable; a rising edge arms the first-break check |
| rx_i | input | 1 | Raw LIN receive line (idle high) |
| bit_div_i | input | DIV_W | Clocks per nominal bit time (0 behaves as 1) |
| brk_max_i | input | BITCNT_W | Break-length limit in bit times for the first break |
| stop_smp_i | input | 1 | Strobe at the stop-bit sample point of a received byte |
| brk_o | output | 1 | Break received pulse |
| brk_long_o | output | 1 | First break reached the length limit pulse |
| edge_ovf_o | output | 1 | Falling-edge count reached 57 pulse |
| frm_err_o | output | 1 | Stop bit sampled low pulse |

## Verification
The bench targets the threshold boundary. A low time one clock short of 11 bit times must stay silent, because a design counting bit ticks off by one would report a break there. It holds the line low for far longer than a break, and repeats breaks after the first, to catch a design that fires while the line is still low or keeps checking length after the first break. It checks that a length equal to the limit counts as long. It drives 60 falling edges to confirm a single overflow at the 57th. It also confirms that a break, and a disable/enable cycle, both restart the edge count and the low-time count. A design that failed to clear either would show a stray overflow or break.

// File: rtl/lin_mon_pkg.sv
package lin_mon_pkg;

    // One registered bit per reported event
    typedef struct packed {
        logic brk;
        logic brk_long;
        logic edge_ovf;
        logic frm_err;
    } lin_evt_t;

endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic rx_s_o,
    output logic rx_prev_o
);
    // STAGES synchronizer flops plus one history flop for edge detection
    localparam int unsigned LEN = STAGES + 1;

    logic [LEN-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LEN-2:0], rx_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign rx_s_o    = sh_q[STAGES-1];
    assign rx_prev_o = sh_q[STAGES];

endmodule

// File: rtl/lin_low_timer.sv
module lin_low_timer #(
    parameter int unsigned DIV_W = 16,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             rx_s_i,
    input  logic [DIV_W-1:0] div_i,
    output logic [CNT_W-1:0] low_bits_o
);
    typedef struct packed {
        logic [DIV_W-1:0] presc;
        logic [CNT_W-1:0] bits;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [DIV_W:0] presc_nx;

    always_comb begin
        tmr_d    = tmr_q;
        presc_nx = {1'b0, tmr_q.presc} + 1'b1;
        if (!en_i || rx_s_i) begin
            tmr_d = '0;
        end else if (presc_nx >= {1'b0, div_i}) begin
            tmr_d.presc = '0;
            if (tmr_q.bits != '1) tmr_d.bits = tmr_q.bits + 1'b1;
        end else begin
            tmr_d.presc = presc_nx[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign low_bits_o = tmr_q.bits;

    AST_BITS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.bits == '1) |=> (tmr_q.bits == '1 || tmr_q.bits == '0)); // R3
    AST_BITS_CLEAR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_s_i || !en_i) |=> (tmr_q.bits == '0)); // R9

endmodule

// File: rtl/lin_edge_counter.sv
module lin_edge_counter #(
    parameter int unsigned LIMIT = 57
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic fall_i,
    input  logic clr_i,
    output logic ovf_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ovf;
    } ec_t;

    ec_t ec_d, ec_q;

    always_comb begin
        ec_d     = ec_q;
        ec_d.ovf = 1'b0;
        if (!en_i) begin
            ec_d = '0;
        end else if (clr_i) begin
            ec_d.cnt = '0;
        end else if (fall_i && ec_q.cnt < LIM) begin
            ec_d.cnt = ec_q.cnt + 1'b1;
            ec_d.ovf = (ec_q.cnt == LIM - 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ec_q <= '0;
        else        ec_q <= ec_d;
    end

    assign ovf_o = ec_q.ovf;

    AST_EDGE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        ec_q.cnt <= LIM); // R6
    AST_OVF_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ec_q.ovf |-> (ec_q.cnt == LIM)); // R6
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && clr_i) |=> (ec_q.cnt == '0)); // R7

endmodule

// File: rtl/lin_brk_mon.sv
module lin_brk_mon
    import lin_mon_pkg::*;
#(
    parameter int unsigned DIV_W      = 16,
    parameter int unsigned BITCNT_W   = 8,
    parameter int unsigned BREAK_BITS = 11,
    parameter int unsigned EDGE_LIMIT = 57,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                rx_i,
    input  logic [DIV_W-1:0]    bit_div_i,
    input  logic [BITCNT_W-1:0] brk_max_i,
    input  logic                stop_smp_i,
    output logic                brk_o,
    output logic                brk_long_o,
    output logic                edge_ovf_o,
    output logic                frm_err_o
);
    localparam logic [BITCNT_W-1:0] BRK_THR = BITCNT_W'(BREAK_BITS);

    typedef struct packed {
        logic     en_prev;
        logic     first;
        lin_evt_t evt;
    } mon_t;

    mon_t mon_d, mon_q;

    logic rx_s, rx_prev;
    logic [BITCNT_W-1:0] low_bits;
    logic rise, fall, brk_hit, ovf;

    lin_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_i      (rx_i),
        .rx_s_o    (rx_s),
        .rx_prev_o (rx_prev)
    );

    lin_low_timer #(.DIV_W(DIV_W), .CNT_W(BITCNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .rx_s_i     (rx_s),
        .div_i      (bit_div_i),
        .low_bits_o (low_bits)
    );

    assign rise    = rx_s & ~rx_prev;
    assign fall    = ~rx_s & rx_prev;
    assign brk_hit = en_i & rise & (low_bits >= BRK_THR);

    lin_edge_counter #(.LIMIT(EDGE_LIMIT)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .fall_i (fall),
        .clr_i  (brk_hit),
        .ovf_o  (ovf)
    );

    always_comb begin
        mon_d         = mon_q;
        mon_d.en_prev = en_i;
        mon_d.evt     = '0;
        if (!en_i) begin
            mon_d.first = 1'b0;
        end else if (brk_hit) begin
            mon_d.first = 1'b0;
        end else if (!mon_q.en_prev) begin
            mon_d.first = 1'b1;
        end
        mon_d.evt.brk      = brk_hit;
        mon_d.evt.brk_long = brk_hit & mon_q.first & (low_bits >= brk_max_i);
        mon_d.evt.frm_err  = en_i & stop_smp_i & ~rx_s;
        mon_d.evt.edge_ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    assign brk_o      = mon_q.evt.brk;
    assign brk_long_o = mon_q.evt.brk_long;
    assign frm_err_o  = mon_q.evt.frm_err;
    assign edge_ovf_o = ovf;

    AST_BRK_LOW_LONG_ENOUGH: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |-> ($past(low_bits) >= BRK_THR)); // R1
    AST_BRK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |=> !brk_o); // R3
    AST_LONG_NEEDS_BRK: assert property (@(posedge clk) disable iff (!rst_n)
        brk_long_o |-> brk_o); // R4
    AST_FIRST_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |-> !mon_q.first); // R5
    AST_FRM_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err_o |-> $past(stop_smp_i && !rx_s)); // R8
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !(brk_o || brk_long_o || edge_ovf_o || frm_err_o)); // R9

endmodule

// File: tb/lin_brk_mon_bench.sv
`timescale 1ns/1ps
module lin_brk_mon_bench;
    localparam int DIV  = 4;
    localparam int BMAX = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic rx = 1'b1;
    logic [15:0] div = 16'(DIV);
    logic [7:0]  bmax = 8'(BMAX);
    logic stop = 1'b0;
    logic brk, brk_long, ovf, frm;

    int vectors = 0;
    int errors  = 0;
    string cur_req = "R10";

    always #2.5 clk = ~clk;

    lin_brk_mon u_lin_brk_mon (
        .clk(clk), .rst_n(rst_n), .en_i(en), .rx_i(rx),
        .bit_div_i(div), .brk_max_i(bmax), .stop_smp_i(stop),
        .brk_o(brk), .brk_long_o(brk_long), .edge_ovf_o(ovf), .frm_err_o(frm)
    );

    // behavioural reference: integers counting low clocks, edges and pulses
    int m_s1 = 1, m_s2 = 1, m_prev = 1;
    int low_clk = 0, ecnt = 0;
    bit first = 0, en_prev = 0;
    bit x_brk = 0, x_long = 0, x_ovf = 0, x_frm = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_prev = 1;
            low_clk = 0; ecnt = 0; first = 0; en_prev = 0;
            x_brk = 0; x_long = 0; x_ovf = 0; x_frm = 0;
        end else begin
            int bits;
            bit r, f, b;
            x_brk = 0; x_long = 0; x_ovf = 0; x_frm = 0;
            if (!en) begin
                low_clk = 0; ecnt = 0; first = 0;
            end else begin
                r = (m_prev == 0) && (m_s2 == 1);
                f = (m_prev == 1) && (m_s2 == 0);
                bits = low_clk / DIV;
                if (bits > 255) bits = 255;
                b = r && (low_clk >= 11 * DIV);
                x_brk  = b;
                x_long = b && first && (bits >= BMAX);
                if (b) first = 0;
                else if (!en_prev) first = 1;
                if (b) ecnt = 0;
                else if (f && ecnt < 57) begin
                    ecnt++;
                    if (ecnt == 57) x_ovf = 1;
                end
                x_frm = stop && (m_s2 == 0);
                low_clk = (m_s2 == 0) ? low_clk + 1 : 0;
            end
            en_prev = en;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = rx;
        end
    end

    task automatic cmp(string nm, logic act, bit exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", cur_req, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        vectors++;
        cmp("brk_o", brk, x_brk);
        cmp("brk_long_o", brk_long, x_long);
        cmp("edge_ovf_o", ovf, x_ovf);
        cmp("frm_err_o", frm, x_frm);
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int lo, int hi);
        rx = 1'b0; idle(lo);
        rx = 1'b1; idle(hi);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        cur_req = "R10"; idle(4);
        rst_n = 1'b1; idle(4);
        @(negedge clk); en = 1'b1; idle(4);
        cur_req = "R2"; pulse(11 * DIV - 1, 8);   // one clock short
        cur_req = "R4"; pulse(15 * DIV, 8);       // first break, long
        cur_req = "R5"; pulse(15 * DIV, 8);       // later break, never long
        cur_req = "R1"; pulse(11 * DIV, 8);       // exactly at threshold
        cur_req = "R3"; pulse(200, 8);            // held low
        cur_req = "R5"; en = 1'b0; idle(3); en = 1'b1; idle(3);
        pulse(11 * DIV, 8);                        // rearmed, short first break
        cur_req = "R4"; en = 1'b0; idle(3); en = 1'b1; idle(3);
        pulse(BMAX * DIV, 8);                      // equal to limit is long
        cur_req = "R6";
        for (int i = 0; i < 60; i++) pulse(2, 2);
        idle(6);
        cur_req = "R7"; pulse(12 * DIV, 6);
        for (int i = 0; i < 56; i++) pulse(2, 2);
        idle(6);
        pulse(2, 2);                               // 57th after the break
        idle(6);
        cur_req = "R8";
        @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0; idle(3);
        rx = 1'b0; idle(4);
        stop = 1'b1; @(negedge clk); stop = 1'b0; idle(3);
        rx = 1'b1; idle(6);
        cur_req = "R9";
        rx = 1'b0; idle(30);
        en = 1'b0; idle(3); en = 1'b1;
        idle(20); rx = 1'b1; idle(6);              // partial low must not add up
        for (int i = 0; i < 30; i++) pulse(2, 2);
        en = 1'b0; idle(3); en = 1'b1;
        for (int i = 0; i < 30; i++) pulse(2, 2);  // count restarted
        en = 1'b0;
        stop = 1'b1; rx = 1'b0; idle(4); stop = 1'b0; rx = 1'b1;
        pulse(15 * DIV, 8);                        // disabled: silent
        idle(6);
        summary();
    end
endmodule